// File: doc/BRIEF.md
# Flash Page ECC Syndrome Checker

This block judges one or two 256-byte chunks of a flash page read by comparing, for each chunk, the 24-bit Hamming code freshly computed over the data with the 24-bit code that was fetched from the spare area. The XOR of the two codes is the syndrome. Its population count, and whether its two 11-bit halves are bitwise complements, decide the verdict: clean, a damaged code field, one flipped data bit that can be repaired, or damage beyond repair.

On a repairable error the block gives the byte index inside the chunk and an 8-bit flip mask. The surrounding read path applies these with one read-modify-write on its buffer. In wide mode, which covers a 512-byte page, the block checks the second code pair one cycle after the first. It then reports a combined failure flag that covers both chunks.

Control is a three-state machine. The states are ST_IDLE, ST_FIRST (the first chunk's verdict is being formed) and ST_SECOND (the second chunk's verdict is being formed). The transitions are:
- ST_IDLE to ST_FIRST when `start` is high.
- ST_FIRST to ST_SECOND when the captured wide flag is set.
- ST_FIRST to ST_IDLE when the captured wide flag is clear.
- ST_SECOND to ST_IDLE, always.

Top module: `ecc_syndrome_checker`

## Requirements
- R1: When the two codes of a chunk are equal, the verdict `status` is 2'b00 (clean), `err_byte` and `err_mask` are zero, and the chunk does not fail.
- R2: When either the computed or the stored code of a chunk is all zeros, the verdict is 2'b00 (clean), whatever the other code holds.
- R3: A syndrome with exactly one set bit, at any of the 24 positions, gives `status` 2'b10 (code field damaged). `err_byte` and `err_mask` are then zero and the chunk fails.
- R4: A syndrome with exactly 11 set bits whose bits [10:0] XOR bits [21:11] equal 11'h7FF gives `status` 2'b01 (repairable). `err_byte` is then syndrome bits [10:3], `err_mask` has only bit number syndrome[2:0] set, and the chunk does not fail.
- R5: Any other syndrome gives `status` 2'b11 (not repairable), with `err_byte` and `err_mask` zero, and the chunk fails. This includes 11 set bits whose halves are not complements.
- R6: `start` is accepted only in ST_IDLE. If it is sampled high at clock edge N, `done` is high for exactly one cycle after edge N+1, with `chunk` = 0, and it carries the verdict for `calc_a`/`stored_a`. The code inputs need not be held after edge N.
- R7: In wide mode (`wide_mode` high when `start` is accepted), a second `done` follows in the very next cycle. It has `chunk` = 1 and `last` = 1, and it judges `calc_b`/`stored_b` as they were captured at edge N. Its `fail` is the OR of both chunks' failures.
- R8: In narrow mode, the single result has `last` = 1, and `fail` is high exactly when `status` is 2'b10 or 2'b11.
- R9: A `start` that arrives while a check is in progress is ignored. No extra `done` follows.
- R10: After reset, `done`, `last`, `chunk`, `status`, `err_byte`, `err_mask` and `fail` are all zero.
- R11: Between `done` pulses, all result outputs keep the value they last took.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a check, sampled in ST_IDLE |
| wide_mode | input | 1 | Check two chunks (512-byte page) |
| calc_a | input | 24 | Computed code, first chunk |
| stored_a | input | 24 | Stored code, first chunk |
| calc_b | input | 24 | Computed code, second chunk |
| stored_b | input | 24 | Stored code, second chunk |
| done | output | 1 | One-cycle pulse per judged chunk |
| last | output | 1 | This result is the final one of the check |
| chunk | output | 1 | Chunk index of this result |
| status | output | 2 | 00 clean, 01 repaired, 10 code damaged, 11 not repairable |
| err_byte | output | 8 | Byte index to repair |
| err_mask | output | 8 | Bit mask to XOR into that byte |
| fail | output | 1 | Accumulated failure over the chunks of this check |

## Verification
A new `start` can land in the same cycle in which the machine, in ST_FIRST, produces a verdict and drops back to ST_IDLE. The bench provokes this by raising `start` again, with different codes, in the cycle right after an accepted start. It then requires that the reported verdict belongs to the first codes and that no further `done` appears in the following cycles. A second pairing is the wide-mode hand-off: the edge that produces the first chunk's verdict also loads the second syndrome. The bench judges this by checking both verdicts, on consecutive cycles, against codes whose classes differ, and by checking that the combined failure flag is correct.

// File: rtl/ecc_chk_pkg.sv
`timescale 1ns/1ps
package ecc_chk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } chk_state_t;

    typedef enum logic [1:0] {
        RES_CLEAN = 2'b00,
        RES_FIXED = 2'b01,
        RES_CODE  = 2'b10,
        RES_BAD   = 2'b11
    } chk_res_t;
endpackage

// File: rtl/ecc_chk_capture.sv
`timescale 1ns/1ps
// Stage 1: forms the syndrome, flags an all-zero code, and registers
// per-group popcounts (first level of the adder tree).
module ecc_chk_capture #(
    parameter int CODE_W = 24,
    parameter int HALF_W = 11,
    parameter int GRP_W  = 8,
    localparam int NGRP  = (CODE_W + GRP_W - 1) / GRP_W,
    localparam int CNT_W = $clog2(GRP_W + 1),
    localparam int PAD_W = NGRP * GRP_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [CODE_W-1:0]       calc,
    input  logic [CODE_W-1:0]       stored,
    output logic [2*HALF_W-1:0]     syn_q,
    output logic                    quiet_q,
    output logic [NGRP*CNT_W-1:0]   grp_cnt_q
);
    logic [CODE_W-1:0] syn_d;
    logic [PAD_W-1:0]  syn_pad;

    assign syn_d   = calc ^ stored;
    assign syn_pad = PAD_W'(syn_d);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            syn_q   <= '0;
            quiet_q <= 1'b1;
        end else if (load) begin
            syn_q   <= syn_d[2*HALF_W-1:0];
            quiet_q <= (syn_d == '0) || (calc == '0) || (stored == '0);
        end
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic [CNT_W-1:0] cnt_d;
        always_comb begin
            cnt_d = '0;
            for (int b = 0; b < GRP_W; b++)
                cnt_d = cnt_d + CNT_W'(syn_pad[g*GRP_W + b]);
        end
        always_ff @(posedge clk) begin
            if (!rst_n)
                grp_cnt_q[g*CNT_W +: CNT_W] <= '0;
            else if (load)
                grp_cnt_q[g*CNT_W +: CNT_W] <= cnt_d;
        end
    end
endmodule

// File: rtl/ecc_chk_judge.sv
`timescale 1ns/1ps
// Stage 2: finishes the popcount and classifies the syndrome.
module ecc_chk_judge
    import ecc_chk_pkg::*;
#(
    parameter int CODE_W = 24,
    parameter int HALF_W = 11,
    parameter int GRP_W  = 8,
    parameter int BIT_W  = 3,
    localparam int NGRP   = (CODE_W + GRP_W - 1) / GRP_W,
    localparam int CNT_W  = $clog2(GRP_W + 1),
    localparam int TOT_W  = $clog2(NGRP * GRP_W + 1),
    localparam int BYTE_W = HALF_W - BIT_W,
    localparam int MASK_W = 1 << BIT_W
) (
    input  logic [2*HALF_W-1:0]   syn,
    input  logic                  quiet,
    input  logic [NGRP*CNT_W-1:0] grp_cnt,
    output chk_res_t              verdict,
    output logic [BYTE_W-1:0]     byte_idx,
    output logic [MASK_W-1:0]     flip_mask
);
    logic [TOT_W-1:0] total;
    logic             halves_ok;

    always_comb begin
        total = '0;
        for (int g = 0; g < NGRP; g++)
            total = total + TOT_W'(grp_cnt[g*CNT_W +: CNT_W]);
    end

    assign halves_ok = &(syn[HALF_W-1:0] ^ syn[2*HALF_W-1:HALF_W]);

    always_comb begin
        byte_idx  = '0;
        flip_mask = '0;
        if (quiet)
            verdict = RES_CLEAN;
        else if (total == TOT_W'(1))
            verdict = RES_CODE;
        else if (total == TOT_W'(HALF_W) && halves_ok) begin
            verdict   = RES_FIXED;
            byte_idx  = syn[HALF_W-1:BIT_W];
            flip_mask = MASK_W'(1) << syn[BIT_W-1:0];
        end else
            verdict = RES_BAD;
    end
endmodule

// File: rtl/ecc_syndrome_checker.sv
`timescale 1ns/1ps
module ecc_syndrome_checker
    import ecc_chk_pkg::*;
#(
    parameter int CODE_W = 24,
    parameter int HALF_W = 11,
    parameter int GRP_W  = 8,
    parameter int BIT_W  = 3,
    localparam int NGRP   = (CODE_W + GRP_W - 1) / GRP_W,
    localparam int CNT_W  = $clog2(GRP_W + 1),
    localparam int BYTE_W = HALF_W - BIT_W,
    localparam int MASK_W = 1 << BIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wide_mode,
    input  logic [CODE_W-1:0] calc_a,
    input  logic [CODE_W-1:0] stored_a,
    input  logic [CODE_W-1:0] calc_b,
    input  logic [CODE_W-1:0] stored_b,
    output logic              done,
    output logic              last,
    output logic              chunk,
    output logic [1:0]        status,
    output logic [BYTE_W-1:0] err_byte,
    output logic [MASK_W-1:0] err_mask,
    output logic              fail
);
    chk_state_t state, state_nx;

    logic [CODE_W-1:0]     calc_b_q, stored_b_q;
    logic                  wide_q;
    logic                  load;
    logic [CODE_W-1:0]     calc_sel, stored_sel;
    logic [2*HALF_W-1:0]   syn_q;
    logic                  quiet_q;
    logic [NGRP*CNT_W-1:0] grp_cnt_q;
    chk_res_t              verdict;
    logic [BYTE_W-1:0]     byte_idx;
    logic [MASK_W-1:0]     flip_mask;

    // Syndrome loads: first chunk on an accepted start, second chunk on the
    // ST_FIRST edge of a wide check.
    assign load       = (state == ST_IDLE && start) || (state == ST_FIRST && wide_q);
    assign calc_sel   = (state == ST_FIRST) ? calc_b_q   : calc_a;
    assign stored_sel = (state == ST_FIRST) ? stored_b_q : stored_a;

    ecc_chk_capture #(.CODE_W(CODE_W), .HALF_W(HALF_W), .GRP_W(GRP_W)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .calc      (calc_sel),
        .stored    (stored_sel),
        .syn_q     (syn_q),
        .quiet_q   (quiet_q),
        .grp_cnt_q (grp_cnt_q)
    );

    ecc_chk_judge #(.CODE_W(CODE_W), .HALF_W(HALF_W), .GRP_W(GRP_W), .BIT_W(BIT_W)) u_judge (
        .syn       (syn_q),
        .quiet     (quiet_q),
        .grp_cnt   (grp_cnt_q),
        .verdict   (verdict),
        .byte_idx  (byte_idx),
        .flip_mask (flip_mask)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_FIRST;
            ST_FIRST:  state_nx = wide_q ? ST_SECOND : ST_IDLE;
            ST_SECOND: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // State register and the second-chunk code hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            calc_b_q   <= '0;
            stored_b_q <= '0;
            wide_q     <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && start) begin
                calc_b_q   <= calc_b;
                stored_b_q <= stored_b;
                wide_q     <= wide_mode;
            end
        end
    end

    // Result outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            last     <= 1'b0;
            chunk    <= 1'b0;
            status   <= RES_CLEAN;
            err_byte <= '0;
            err_mask <= '0;
            fail     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_FIRST: begin
                    done     <= 1'b1;
                    chunk    <= 1'b0;
                    last     <= !wide_q;
                    status   <= verdict;
                    err_byte <= byte_idx;
                    err_mask <= flip_mask;
                    fail     <= verdict[1];
                end
                ST_SECOND: begin
                    done     <= 1'b1;
                    chunk    <= 1'b1;
                    last     <= 1'b1;
                    status   <= verdict;
                    err_byte <= byte_idx;
                    err_mask <= flip_mask;
                    fail     <= fail | verdict[1];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ecc_syndrome_checker_sva.sv
`timescale 1ns/1ps
module ecc_syndrome_checker_sva #(
    parameter int BYTE_W = 8,
    parameter int MASK_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              done,
    input logic              last,
    input logic              chunk,
    input logic [1:0]        status,
    input logic [BYTE_W-1:0] err_byte,
    input logic [MASK_W-1:0] err_mask,
    input logic              fail
);
    a_r3_code_field_no_fix: assert property (@(posedge clk) disable iff (!rst_n)
        done && status == 2'b10 |-> err_byte == '0 && err_mask == '0);
    a_r4_fix_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
        done && status == 2'b01 |-> $countones(err_mask) == 1);
    a_r5_bad_no_fix: assert property (@(posedge clk) disable iff (!rst_n)
        done && status == 2'b11 |-> err_byte == '0 && err_mask == '0);
    a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done && !chunk |-> $past(start, 2));
    a_r6_final_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done && last |=> !done);
    a_r7_follows_first: assert property (@(posedge clk) disable iff (!rst_n)
        done && chunk |-> last && $past(done) && !$past(chunk));
    a_r7_fail_or: assert property (@(posedge clk) disable iff (!rst_n)
        done && chunk |-> fail == ($past(fail) || status[1]));
    a_r8_first_fail: assert property (@(posedge clk) disable iff (!rst_n)
        done && !chunk |-> fail == status[1]);
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(status) && $stable(err_byte) && $stable(err_mask) && $stable(fail));
endmodule

bind ecc_syndrome_checker ecc_syndrome_checker_sva #(.BYTE_W(BYTE_W), .MASK_W(MASK_W)) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .done     (done),
    .last     (last),
    .chunk    (chunk),
    .status   (status),
    .err_byte (err_byte),
    .err_mask (err_mask),
    .fail     (fail)
);

// File: tb/ecc_syndrome_checker_test.sv
`timescale 1ns/1ps
module ecc_syndrome_checker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        wide_mode = 1'b0;
    logic [23:0] calc_a = '0, stored_a = '0, calc_b = '0, stored_b = '0;
    logic        done, last, chunk, fail;
    logic [1:0]  status;
    logic [7:0]  err_byte, err_mask;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    ecc_syndrome_checker uut (
        .clk(clk), .rst_n(rst_n), .start(start), .wide_mode(wide_mode),
        .calc_a(calc_a), .stored_a(stored_a), .calc_b(calc_b), .stored_b(stored_b),
        .done(done), .last(last), .chunk(chunk), .status(status),
        .err_byte(err_byte), .err_mask(err_mask), .fail(fail)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected {status, byte, mask}, taken from the requirement text.
    function automatic logic [17:0] model(input logic [23:0] c, input logic [23:0] s);
        logic [23:0] y;
        y = c ^ s;
        if (y == 0 || c == 0 || s == 0) return {2'b00, 16'h0};
        if ($countones(y) == 1) return {2'b10, 16'h0};
        if ($countones(y) == 11 && (y[10:0] ^ y[21:11]) == 11'h7FF)
            return {2'b01, y[10:3], 8'(8'h1 << y[2:0])};
        return {2'b11, 16'h0};
    endfunction

    function automatic logic [23:0] fix_syn(input logic [10:0] lo);
        return {2'b00, ~lo, lo};
    endfunction

    task automatic cmp_result(input logic [17:0] e, input string tag);
        chk(done === 1'b1, {tag, " done"}, 32'(done), 1);
        chk({status, err_byte, err_mask} === e, {tag, " verdict"}, 32'({status, err_byte, err_mask}), 32'(e));
    endtask

    task automatic run_one(input logic [23:0] c, input logic [23:0] s, input string tag);
        logic [17:0] e;
        e = model(c, s);
        @(negedge clk);
        start = 1'b1; wide_mode = 1'b0; calc_a = c; stored_a = s;
        @(negedge clk);
        start = 1'b0; calc_a = ~c; stored_a = c;
        @(negedge clk);
        cmp_result(e, tag);
        chk(last === 1'b1 && chunk === 1'b0, {tag, " R8 last/chunk"}, 32'({last, chunk}), 32'h2);
        chk(fail === e[17], {tag, " R8 fail"}, 32'(fail), 32'(e[17]));
        @(negedge clk);
        chk(done === 1'b0, {tag, " R6 single pulse"}, 32'(done), 0);
        chk({status, err_byte, err_mask} === e, {tag, " R11 hold"}, 32'({status, err_byte, err_mask}), 32'(e));
    endtask

    task automatic run_two(input logic [23:0] c0, input logic [23:0] s0,
                           input logic [23:0] c1, input logic [23:0] s1, input string tag);
        logic [17:0] e0, e1;
        e0 = model(c0, s0);
        e1 = model(c1, s1);
        @(negedge clk);
        start = 1'b1; wide_mode = 1'b1; calc_a = c0; stored_a = s0; calc_b = c1; stored_b = s1;
        @(negedge clk);
        start = 1'b0; wide_mode = 1'b0; calc_b = ~c1; stored_b = c1;
        @(negedge clk);
        cmp_result(e0, {tag, " R7 first"});
        chk(last === 1'b0 && chunk === 1'b0, {tag, " R7 first last/chunk"}, 32'({last, chunk}), 0);
        @(negedge clk);
        cmp_result(e1, {tag, " R7 second"});
        chk(last === 1'b1 && chunk === 1'b1, {tag, " R7 second last/chunk"}, 32'({last, chunk}), 3);
        chk(fail === (e0[17] | e1[17]), {tag, " R7 fail OR"}, 32'(fail), 32'(e0[17] | e1[17]));
        @(negedge clk);
        chk(done === 1'b0, {tag, " R7 end"}, 32'(done), 0);
    endtask

    // R9: a second start in the cycle the first verdict is being produced.
    task automatic busy_start();
        logic [17:0] e;
        e = model(24'h123456, 24'h123456 ^ fix_syn(11'h2D3));
        @(negedge clk);
        start = 1'b1; wide_mode = 1'b0; calc_a = 24'h123456; stored_a = 24'h123456 ^ fix_syn(11'h2D3);
        @(negedge clk);
        calc_a = 24'h00FFFF; stored_a = 24'h00FFF0;
        @(negedge clk);
        start = 1'b0;
        cmp_result(e, "R9 busy first");
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(done === 1'b0, "R9 no extra done", 32'(done), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk({done, last, chunk, status, err_byte, err_mask, fail} === '0, "R10 reset",
            32'({done, last, chunk, status, err_byte, err_mask, fail}), 0);
        rst_n = 1'b1;
        run_one(24'h3C5A96, 24'h3C5A96, "R1 equal");
        run_one(24'h000000, 24'h00F0F0, "R2 calc zero");
        run_one(24'h123456, 24'h000000, "R2 stored zero");
        run_one(24'h5A5A5A, 24'h5A5A5A ^ 24'h000400, "R3 bit10");
        run_one(24'h5A5A5A, 24'h5A5A5A ^ 24'h800000, "R3 bit23");
        run_one(24'h123456, 24'h123456 ^ fix_syn(11'h2D3), "R4 byte5A bit3");
        run_one(24'h654321, 24'h654321 ^ fix_syn(11'h7FF), "R4 byteFF bit7");
        run_one(24'h654321, 24'h654321 ^ fix_syn(11'h000), "R4 byte00 bit0");
        run_one(24'hABCDEF, 24'hABCDEF ^ 24'h000003, "R5 two bits");
        run_one(24'hABCDEF, 24'hABCDEF ^ 24'h4007FE, "R5 eleven not complement");
        run_two(24'h111111, 24'h111111 ^ fix_syn(11'h155), 24'h222222, 24'h222222, "wide fix+clean");
        run_two(24'h333333, 24'h333333 ^ 24'h000010, 24'h444444, 24'h444444, "wide code+clean");
        run_two(24'h555555, 24'h555555, 24'h666666, 24'h666666 ^ 24'h0F0000, "wide clean+bad");
        busy_start();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #100000;
        n_fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule